// File: doc/BRIEF.md
# Byte Mailbox Register Port

This block is the device-facing register port of a byte-stream command mailbox. A host on a simple synchronous bus sees two locations: location 0 carries payload bytes in both directions, and location 1 returns a status byte when read and accepts a command code when written. Behind the port sits a command engine. The port hands it the bytes the host wrote, through a valid/ready stream. It takes response bytes from the engine through a second valid/ready stream, and it raises single-cycle strobes when a command begins, ends or is cancelled.

The host follows a handshake on the status flags. Before each write it waits for the input-busy flag to clear. It opens a command with the start code, pushes the payload while the accepting-data flag is set, and closes with the end code. It then collects the response byte by byte while the output-full flag is set. The port frames each response on its own. A control byte of 0x01 goes ahead of the payload and a control byte of 0x03 follows it, and both carry a framing flag in the status byte so the host cannot mistake them for payload. A cancel code is honoured at any moment and returns the port to its idle, ready-for-command state.

Top module: `mbx_port`

## Requirements
- R1: Reads are registered: `bus_rdata` holds the addressed value the cycle after `bus_rd`, sampled before that edge's updates. Status (location 1) is {2'b0, accepting-data (bit 5), ready-for-command (bit 4), spare 0 (bit 3), framing flag (bit 2), input busy (bit 1), output full (bit 0)}. After reset it reads 0x10.
- R2: A host write to location 0 or 1 that is accepted sets input busy until the port or engine takes the byte. A command byte is taken on the following clock edge. Any write other than cancel made while input busy is set is dropped.
- R3: Taking command 0x01 sets accepting-data, clears ready-for-command, and pulses `cmd_start` for one cycle. The three strobes never overlap.
- R4: A data byte accepted while accepting-data is set appears on `in_data` with `in_valid` high and is held until a cycle with `in_ready` high. Input busy clears after that cycle.
- R5: A data write while accepting-data is clear is ignored: input busy stays clear and nothing reaches the input stream.
- R6: Taking command 0x03 while accepting-data is set clears accepting-data and pulses `cmd_end`.
- R7: Each response appears at location 0 as control byte 0x01, then the engine's payload bytes in order, then control byte 0x03 after the byte marked `rsp_last`. The framing flag (status bit 2) is set while a control byte is in the output buffer and clear while a payload byte is.
- R8: A read of location 0 while output full is set returns the buffered byte and clears output full.
- R9: A read of location 0 while output full is clear returns the last byte presented and changes no flag.
- R10: Writing command 0x22 takes effect on its own write edge in any state, even with input busy set. It clears input busy, output full and accepting-data, sets ready-for-command, pulses `cmd_cancel`, and restarts response framing so that the next response again opens with 0x01.
- R11: Ready-for-command is set again when the host reads the closing 0x03 control byte of a response.
- R12: A command code other than 0x01, 0x03 or 0x22 is taken and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Location select: 0 data, 1 status/command |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| in_valid | output | 1 | Host byte available to the engine |
| in_data | output | 8 | Host byte |
| in_ready | input | 1 | Engine takes the host byte |
| rsp_valid | input | 1 | Engine offers a response byte |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Offered byte is the last payload byte |
| rsp_ready | output | 1 | Port takes the offered response byte |
| cmd_start | output | 1 | One-cycle strobe: start code taken |
| cmd_end | output | 1 | One-cycle strobe: end code taken |
| cmd_cancel | output | 1 | One-cycle strobe: cancel code taken |

## Verification
The bench writes a second data byte while the first is still held, and checks that the held byte does not change. A port that let later writes through would overwrite a byte the engine had not yet taken. It issues cancel both with input busy set and with a start control byte waiting unread. A design that queued cancel behind the busy flag, or left the framer mid-response, would report busy after the cancel or open the next response without 0x01. It reads the data location while the output buffer is empty and checks that the value and flags do not move; a design that treated that read as a take would corrupt the flags. It also checks that ready-for-command comes back only when the closing control byte is read, so a design that raised it early, at the end code, would be caught.

// File: rtl/mbx_pkg.sv
// Shared widths, codes and status bit positions for the mailbox port.
package mbx_pkg;
    localparam int DW = 8;
    typedef logic [DW-1:0] byte_t;

    // Command codes written to location 1
    localparam byte_t CODE_OPEN   = 8'h01;
    localparam byte_t CODE_CLOSE  = 8'h03;
    localparam byte_t CODE_ABORT  = 8'h22;

    // Control bytes framing a response
    localparam byte_t MARK_HEAD   = 8'h01;
    localparam byte_t MARK_TAIL   = 8'h03;

    // Status bit positions
    localparam int SB_OUT_FULL  = 0;
    localparam int SB_IN_BUSY   = 1;
    localparam int SB_FRAME     = 2;
    localparam int SB_SPARE     = 3;
    localparam int SB_CMD_RDY   = 4;
    localparam int SB_DATA_RDY  = 5;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_BODY,
        TX_TAIL
    } tx_state_e;
endpackage

// File: rtl/mbx_rx_path.sv
// Inbound side: holds one host byte (data or command), decodes commands,
// keeps the mode flags and drives the command strobes.
// Assumes the caller has already split writes by location; cancel is
// detected here combinationally so it can act on its own write edge.
module mbx_rx_path
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_data,
    input  logic  wr_cmd,
    input  byte_t wdata,
    input  logic  in_ready,
    input  logic  rsp_done,
    output logic  in_busy,
    output logic  data_mode,
    output logic  cmd_rdy,
    output logic  in_valid,
    output byte_t in_data,
    output logic  abort_now,
    output logic  cmd_start,
    output logic  cmd_end,
    output logic  cmd_cancel
);
    byte_t hold_q;
    logic  hold_is_cmd;

    assign abort_now = wr_cmd && (wdata == CODE_ABORT);
    assign in_valid  = in_busy && !hold_is_cmd;
    assign in_data   = hold_q;

    // Holding register, command decode, mode flags and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_busy     <= 1'b0;
            hold_q      <= '0;
            hold_is_cmd <= 1'b0;
            data_mode   <= 1'b0;
            cmd_rdy     <= 1'b1;
            cmd_start   <= 1'b0;
            cmd_end     <= 1'b0;
            cmd_cancel  <= 1'b0;
        end else begin
            cmd_start  <= 1'b0;
            cmd_end    <= 1'b0;
            cmd_cancel <= 1'b0;
            if (rsp_done) begin
                cmd_rdy <= 1'b1;
            end
            if (abort_now) begin
                in_busy     <= 1'b0;
                hold_is_cmd <= 1'b0;
                data_mode   <= 1'b0;
                cmd_rdy     <= 1'b1;
                cmd_cancel  <= 1'b1;
            end else if (!in_busy) begin
                if (wr_cmd) begin
                    in_busy     <= 1'b1;
                    hold_q      <= wdata;
                    hold_is_cmd <= 1'b1;
                end else if (wr_data && data_mode) begin
                    in_busy     <= 1'b1;
                    hold_q      <= wdata;
                    hold_is_cmd <= 1'b0;
                end
            end else if (hold_is_cmd) begin
                in_busy <= 1'b0;
                if (hold_q == CODE_OPEN) begin
                    data_mode <= 1'b1;
                    cmd_rdy   <= 1'b0;
                    cmd_start <= 1'b1;
                end else if (hold_q == CODE_CLOSE && data_mode) begin
                    data_mode <= 1'b0;
                    cmd_end   <= 1'b1;
                end
            end else if (in_ready) begin
                in_busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mbx_tx_path.sv
// Outbound side: one-byte output buffer plus the response framer that
// wraps the engine's payload between head and tail control bytes.
// Assumes host_take is only meaningful while the buffer is full.
module mbx_tx_path
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  host_take,
    input  logic  rsp_valid,
    input  byte_t rsp_data,
    input  logic  rsp_last,
    output logic  rsp_ready,
    output logic  out_full,
    output logic  out_ctl,
    output byte_t out_byte,
    output logic  rsp_done
);
    tx_state_e state_q;

    assign rsp_ready = (state_q == TX_BODY) && !out_full && !clear;
    assign rsp_done  = host_take && out_full && out_ctl && (out_byte == MARK_TAIL);

    // Framer state and output buffer loading / draining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TX_IDLE;
            out_full <= 1'b0;
            out_ctl  <= 1'b0;
            out_byte <= '0;
        end else if (clear) begin
            state_q  <= TX_IDLE;
            out_full <= 1'b0;
            out_ctl  <= 1'b0;
        end else begin
            if (host_take) begin
                out_full <= 1'b0;
            end
            if (!out_full) begin
                case (state_q)
                    TX_IDLE: if (rsp_valid) begin
                        out_byte <= MARK_HEAD;
                        out_ctl  <= 1'b1;
                        out_full <= 1'b1;
                        state_q  <= TX_BODY;
                    end
                    TX_BODY: if (rsp_valid) begin
                        out_byte <= rsp_data;
                        out_ctl  <= 1'b0;
                        out_full <= 1'b1;
                        if (rsp_last) state_q <= TX_TAIL;
                    end
                    default: begin
                        out_byte <= MARK_TAIL;
                        out_ctl  <= 1'b1;
                        out_full <= 1'b1;
                        state_q  <= TX_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mbx_port.sv
// Top of the mailbox register port: splits bus accesses between the two
// locations, assembles the status byte and registers read data.
// Assumes at most one of bus_rd / bus_wr per cycle.
module mbx_port
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        in_valid,
    output logic [7:0]  in_data,
    input  logic        in_ready,
    input  logic        rsp_valid,
    input  logic [7:0]  rsp_data,
    input  logic        rsp_last,
    output logic        rsp_ready,
    output logic        cmd_start,
    output logic        cmd_end,
    output logic        cmd_cancel
);
    logic  in_busy, data_mode, cmd_rdy, abort_now;
    logic  out_full, out_ctl, rsp_done;
    byte_t out_byte;
    byte_t stat;

    logic wr_data, wr_cmd, host_take;
    assign wr_data   = bus_wr && !bus_addr;
    assign wr_cmd    = bus_wr &&  bus_addr;
    assign host_take = bus_rd && !bus_addr && out_full;

    always_comb begin
        stat                = '0;
        stat[SB_OUT_FULL]   = out_full;
        stat[SB_IN_BUSY]    = in_busy;
        stat[SB_FRAME]      = out_full && out_ctl;
        stat[SB_SPARE]      = 1'b0;
        stat[SB_CMD_RDY]    = cmd_rdy;
        stat[SB_DATA_RDY]   = data_mode;
    end

    mbx_rx_path u_rx (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_cmd(wr_cmd),
        .wdata(bus_wdata), .in_ready(in_ready), .rsp_done(rsp_done),
        .in_busy(in_busy), .data_mode(data_mode), .cmd_rdy(cmd_rdy),
        .in_valid(in_valid), .in_data(in_data), .abort_now(abort_now),
        .cmd_start(cmd_start), .cmd_end(cmd_end), .cmd_cancel(cmd_cancel)
    );

    mbx_tx_path u_tx (
        .clk(clk), .rst_n(rst_n), .clear(abort_now), .host_take(host_take),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .rsp_ready(rsp_ready), .out_full(out_full), .out_ctl(out_ctl),
        .out_byte(out_byte), .rsp_done(rsp_done)
    );

    // Registered read data: status or the last byte presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= bus_addr ? stat : out_byte;
        end
    end
endmodule

// File: rtl/mbx_port_chk.sv
// Temporal checks on the mailbox port, bound onto every mbx_port.
module mbx_port_chk
    import mbx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] stat,
    input logic       in_valid,
    input logic       in_ready,
    input logic       cmd_start,
    input logic       cmd_end,
    input logic       cmd_cancel
);
    logic is_abort;
    assign is_abort = bus_wr && bus_addr && (bus_wdata == CODE_ABORT);

    AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !is_abort && !stat[SB_IN_BUSY]) |=> stat[SB_IN_BUSY]); // R2

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_start, cmd_end, cmd_cancel})); // R3

    AST_HANDOFF_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !is_abort) |=> !in_valid); // R4

    AST_IDLE_DATA_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && !stat[SB_DATA_RDY] && !stat[SB_IN_BUSY]) |=> !stat[SB_IN_BUSY]); // R5

    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr && stat[SB_OUT_FULL]) |=> !stat[SB_OUT_FULL]); // R8

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        is_abort |=> (stat[SB_IN_BUSY] == 1'b0 && stat[SB_OUT_FULL] == 1'b0 &&
                      stat[SB_CMD_RDY] && !stat[SB_DATA_RDY] && cmd_cancel)); // R10
endmodule

bind mbx_port mbx_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .stat(stat),
    .in_valid(in_valid), .in_ready(in_ready), .cmd_start(cmd_start),
    .cmd_end(cmd_end), .cmd_cancel(cmd_cancel)
);

// File: tb/mbx_port_test.sv
// Directed bench for mbx_port: one task per scenario.
module mbx_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       in_valid, in_ready = 1'b0;
    logic [7:0] in_data;
    logic       rsp_valid = 1'b0, rsp_last = 1'b0, rsp_ready;
    logic [7:0] rsp_data = '0;
    logic       cmd_start, cmd_end, cmd_cancel;

    int n_chk = 0, n_bad = 0;
    int n_start = 0, n_end = 0, n_cancel = 0, n_rx = 0;
    logic [7:0] last_rx = '0;

    always #5 clk = ~clk;

    mbx_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .rsp_ready(rsp_ready), .cmd_start(cmd_start), .cmd_end(cmd_end),
        .cmd_cancel(cmd_cancel)
    );

    // Count strobes and input-stream handoffs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_start)  n_start++;
            if (cmd_end)    n_end++;
            if (cmd_cancel) n_cancel++;
            if (in_valid && in_ready) begin
                n_rx++;
                last_rx = in_data;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic offer(input logic [7:0] d, input logic last);
        rsp_valid = 1'b1; rsp_data = d; rsp_last = last;
        @(negedge clk);
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 1'b0; rsp_last = 1'b0;
    endtask

    task automatic take_byte(input logic [7:0] exp, input logic ctl);
        logic [7:0] s, d;
        s = '0;
        while (!s[0]) bus_read(1'b1, s);
        chk("R7 frame flag", s[2], ctl);
        bus_read(1'b0, d);
        chk("R7 response byte", d, exp);
    endtask

    task automatic t_reset;
        logic [7:0] s;
        bus_read(1'b1, s);
        chk("R1 reset status", s, 8'h10);
        chk("R1 no strobes", n_start + n_end + n_cancel, 0);
    endtask

    task automatic t_open;
        logic [7:0] s;
        bus_write(1'b1, 8'h01);
        bus_read(1'b1, s);
        chk("R2 busy after command", s, 8'h12);
        bus_read(1'b1, s);
        chk("R3 data mode status", s, 8'h20);
        chk("R3 start strobe", n_start, 1);
    endtask

    task automatic t_data;
        logic [7:0] s;
        in_ready = 1'b0;
        bus_write(1'b0, 8'hA5);
        bus_read(1'b1, s);
        chk("R2 busy after data", s, 8'h22);
        chk("R4 in_valid", in_valid, 1);
        chk("R4 in_data", in_data, 8'hA5);
        bus_write(1'b0, 8'h77);
        chk("R2 write while busy dropped", in_data, 8'hA5);
        in_ready = 1'b1;
        idle(2);
        chk("R4 one handoff", n_rx, 1);
        chk("R4 handoff byte", last_rx, 8'hA5);
        chk("R4 released", in_valid, 0);
        bus_write(1'b0, 8'h3C);
        idle(3);
        chk("R4 second handoff", n_rx, 2);
        chk("R4 second byte", last_rx, 8'h3C);
    endtask

    task automatic t_close;
        logic [7:0] s;
        bus_write(1'b1, 8'h03);
        idle(1);
        bus_read(1'b1, s);
        chk("R6 status after close", s, 8'h00);
        chk("R6 end strobe", n_end, 1);
    endtask

    task automatic t_idle_data;
        logic [7:0] s;
        bus_write(1'b0, 8'h55);
        bus_read(1'b1, s);
        chk("R5 idle write leaves busy clear", s, 8'h00);
        idle(2);
        chk("R5 nothing handed off", n_rx, 2);
    endtask

    task automatic t_response;
        logic [7:0] s;
        fork
            begin
                offer(8'h11, 1'b0);
                offer(8'h22, 1'b1);
            end
            begin
                take_byte(8'h01, 1'b1);
                take_byte(8'h11, 1'b0);
                take_byte(8'h22, 1'b0);
                take_byte(8'h03, 1'b1);
            end
        join
        bus_read(1'b1, s);
        chk("R8 R11 status after response", s, 8'h10);
    endtask

    task automatic t_empty_read;
        logic [7:0] s, d;
        bus_read(1'b0, d);
        chk("R9 empty read value", d, 8'h03);
        bus_read(1'b1, s);
        chk("R9 flags unchanged", s, 8'h10);
    endtask

    task automatic t_unknown;
        logic [7:0] s;
        bus_write(1'b1, 8'h5A);
        idle(1);
        bus_read(1'b1, s);
        chk("R12 unknown code no effect", s, 8'h10);
        chk("R12 no strobe", n_start + n_end + n_cancel, 2);
    endtask

    task automatic t_cancel;
        logic [7:0] s;
        bus_write(1'b1, 8'h01);
        idle(1);
        in_ready = 1'b0;
        bus_write(1'b0, 8'h99);
        bus_read(1'b1, s);
        chk("R10 busy before cancel", s, 8'h22);
        bus_write(1'b1, 8'h22);
        idle(1);
        bus_read(1'b1, s);
        chk("R10 status after cancel", s, 8'h10);
        chk("R10 input stream cleared", in_valid, 0);
        chk("R10 cancel strobe", n_cancel, 1);
        in_ready = 1'b1;
        rsp_valid = 1'b1; rsp_data = 8'h44; rsp_last = 1'b0;
        s = '0;
        while (!s[0]) bus_read(1'b1, s);
        rsp_valid = 1'b0;
        chk("R10 head pending", s[2], 1);
        bus_write(1'b1, 8'h22);
        idle(1);
        bus_read(1'b1, s);
        chk("R10 output cleared", s, 8'h10);
        chk("R10 second cancel strobe", n_cancel, 2);
        fork
            offer(8'h66, 1'b1);
            begin
                take_byte(8'h01, 1'b1);
                take_byte(8'h66, 1'b0);
                take_byte(8'h03, 1'b1);
            end
        join
    endtask

    initial begin
        fork
            begin
                idle(3);
                rst_n = 1'b1;
                idle(1);
                t_reset();
                t_open();
                t_data();
                t_close();
                t_idle_data();
                t_response();
                t_empty_read();
                t_unknown();
                t_cancel();
            end
            begin
                idle(20000);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule